// File: doc/BRIEF.md
# Serial Byte Shifter with Byte-Complete Flag

This block is the data path of a two-wire serial engine. It holds one byte that software loads before a transfer or collects after one, and it moves that byte over the serial data line one bit per strobe from the bus engine. Outbound bits leave most significant first. Inbound bits enter at the bottom and climb, so the first bit received lands in the top position once the byte is complete.

A byte-complete flag (SI) marks the boundary between bytes. While SI is set, the bus side is frozen: strobes have no effect, and only the CPU may change the byte. While SI is clear, a transfer is in progress: CPU writes are dropped, and reads return the last byte that was stable. The flag sets itself after the final bit strobe of a byte. Software clears it with a one-cycle request, and that clear is what starts the next byte. The flag comes out of reset set, so the first byte can be loaded before any shifting starts.

Top module: `ibs_byte_shifter`

## Requirements
- R1: After reset the held byte and `rd_data` are 0, `si` is 1 and `sda_out` is 0.
- R2: A CPU write while `si` is 1 loads `wr_data` into the byte. The value appears on `rd_data` on the next cycle, and its bit 7 appears on `sda_out`.
- R3: A CPU write while `si` is 0 is ignored. Neither `rd_data` nor the bits later shifted onto `sda_out` change.
- R4: Each `bit_stb` while `si` is 0 moves the byte one place toward bit 7. As a result `sda_out` presents bits 7, 6, ... 0 of the loaded byte in that order, one per strobe.
- R5: Each `bit_stb` while `si` is 0 takes `sda_in` into bit 0. After DATA_W strobes, the first bit sampled is in bit 7 of `rd_data` and the last is in bit 0.
- R6: `si` becomes 1 on the cycle after the DATA_W-th strobe since `si` was last cleared. `rd_data` shows the assembled byte from that same cycle.
- R7: While `si` is 1, `bit_stb` has no effect. The byte, `sda_out` and `si` stay unchanged.
- R8: A `si_clr` pulse while `si` is 1 makes `si` 0 on the next cycle. The next byte starts counting at its first strobe.
- R9: While `si` is 0, `rd_data` holds the last stable byte until the byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | DATA_W | CPU write value |
| rd_data | output | DATA_W | CPU read value (last stable byte) |
| si_clr | input | 1 | Software request to clear the byte-complete flag |
| si | output | 1 | Byte-complete flag |
| bit_stb | input | 1 | One-cycle bit strobe from the bus engine |
| sda_in | input | 1 | Serial data sampled at the strobe |
| sda_out | output | 1 | Serial data presented (current top bit) |

## Verification
The bench builds the block with DATA_W = 8. This gives a 3-bit bit counter whose last count coincides with its wrap, so every byte exercises the terminal count and its restart. Transfers run with random outbound and inbound bytes, including all-ones and all-zeros patterns. Random dropped writes and stray strobes are placed inside and between transfers, which reaches the gating on both sides of the flag.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_LOAD  = 2'd1,
    SH_SHIFT = 2'd2
  } sh_op_e;
endpackage

// File: rtl/ibs_bit_counter.sv
module ibs_bit_counter #(
  parameter int DATA_W = 8,
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic si,
  output logic last_stb
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign last_stb = shift_en && (cnt_q == CW'(DATA_W - 1));

  always_comb begin
    cnt_en = shift_en;
    cnt_d  = last_stb ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8: each byte starts counting from zero while the flag is set
  p_cnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    si |-> (cnt_q == '0));
endmodule

// File: rtl/ibs_si_ctrl.sv
module ibs_si_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic last_stb,
  input  logic si_clr,
  output logic si
);
  logic si_q, si_d, si_en;

  always_comb begin
    si_en = last_stb || (si_clr && si_q);
    si_d  = last_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     si_q <= 1'b1;
    else if (si_en) si_q <= si_d;
  end

  assign si = si_q;

  p_si_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_stb |=> si);
  p_si_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (si && si_clr) |=> !si);
endmodule

// File: rtl/ibs_shift_reg.sv
module ibs_shift_reg
  import ibs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sh_op_e            op,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sda_in,
  input  logic              last_stb,
  input  logic              si,
  output logic              sda_out,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              sh_en, rd_en;
  logic [DATA_W-1:0] shifted;

  assign shifted = {sh_q[DATA_W-2:0], sda_in};

  always_comb begin
    sh_en = (op != SH_HOLD);
    sh_d  = (op == SH_LOAD) ? wr_data : shifted;
    rd_en = (op == SH_LOAD) || last_stb;
    rd_d  = (op == SH_LOAD) ? wr_data : shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign sda_out = sh_q[DATA_W-1];
  assign rd_data = rd_q;

  // R7: nothing on the bus side moves the byte while the flag is set
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (si && (op != SH_LOAD)) |=> $stable(sh_q));
  // R4: the next lower bit is presented after a strobe
  p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!si && op == SH_SHIFT) |=> (sda_out == $past(sh_q[DATA_W-2])));
  // R9: read value held during shifting
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!si && !last_stb) |=> $stable(rd_q));
  // R3: no load is taken while shifting
  p_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !si |-> (op != SH_LOAD));
endmodule

// File: rtl/ibs_byte_shifter.sv
module ibs_byte_shifter
  import ibs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              si_clr,
  output logic              si,
  input  logic              bit_stb,
  input  logic              sda_in,
  output logic              sda_out
);
  logic   shift_en;
  logic   last_stb;
  sh_op_e op;

  always_comb begin
    shift_en = bit_stb && !si;
    if (wr_en && si) op = SH_LOAD;
    else if (shift_en) op = SH_SHIFT;
    else op = SH_HOLD;
  end

  ibs_bit_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .si       (si),
    .last_stb (last_stb)
  );

  ibs_si_ctrl u_si (
    .clk      (clk),
    .rst_n    (rst_n),
    .last_stb (last_stb),
    .si_clr   (si_clr),
    .si       (si)
  );

  ibs_shift_reg #(.DATA_W(DATA_W)) u_sh (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .wr_data  (wr_data),
    .sda_in   (sda_in),
    .last_stb (last_stb),
    .si       (si),
    .sda_out  (sda_out),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/ibs_byte_shifter_tb.sv
module ibs_byte_shifter_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         si_clr = 1'b0;
  logic         si;
  logic         bit_stb = 1'b0;
  logic         sda_in = 1'b0;
  logic         sda_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ibs_byte_shifter #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .si_clr(si_clr), .si(si), .bit_stb(bit_stb),
    .sda_in(sda_in), .sda_out(sda_out)
  );

  function automatic logic bit_at(input logic [W-1:0] b, input int k);
    return b[W-1-k];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [W-1:0] d, input logic c,
                     input logic s, input logic din);
    @(negedge clk);
    wr_en = w; wr_data = d; si_clr = c; bit_stb = s; sda_in = din;
    @(posedge clk); #1;
    wr_en = 0; si_clr = 0; bit_stb = 0;
  endtask

  task automatic transfer(input logic [W-1:0] tx, input logic [W-1:0] rx, input bit noise);
    cyc(1, tx, 0, 0, 0);
    chk("R2 rd_data", rd_data, tx);
    chk("R2 sda_out", {7'b0, sda_out}, {7'b0, tx[W-1]});
    cyc(0, '0, 1, 0, 0);
    chk("R8 si cleared", {7'b0, si}, 8'h00);
    for (int k = 0; k < W; k++) begin
      chk("R4 sda_out bit", {7'b0, sda_out}, {7'b0, bit_at(tx, k)});
      if (noise && ($urandom_range(0, 2) == 0)) begin
        cyc(1, W'($urandom), 0, 0, 0);
        chk("R3 write ignored", rd_data, tx);
        chk("R3 sda_out kept", {7'b0, sda_out}, {7'b0, bit_at(tx, k)});
      end
      chk("R9 rd_data held", rd_data, tx);
      cyc(0, '0, 0, 1, bit_at(rx, k));
      if (k < W - 1) chk("R6 si low mid-byte", {7'b0, si}, 8'h00);
    end
    chk("R6 si set", {7'b0, si}, 8'h01);
    chk("R5 rx byte", rd_data, rx);
    for (int j = 0; j < 2; j++) begin
      cyc(0, '0, 0, 1, ~sda_in);
      chk("R7 si kept", {7'b0, si}, 8'h01);
      chk("R7 rd kept", rd_data, rx);
      chk("R7 sda_out kept", {7'b0, sda_out}, {7'b0, rx[W-1]});
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1;
    chk("R1 rd_data", rd_data, '0);
    chk("R1 si", {7'b0, si}, 8'h01);
    chk("R1 sda_out", {7'b0, sda_out}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    transfer(8'hA5, 8'h3C, 0);
    transfer(8'hFF, 8'h00, 0);
    transfer(8'h00, 8'hFF, 1);
    transfer(8'h80, 8'h01, 1);
    for (int i = 0; i < 25; i++)
      transfer(W'($urandom), W'($urandom), 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule